// File: doc/BRIEF.md
# Dual-Space Internal Data Memory

This block holds the 256-byte on-chip data RAM of a small 8-bit controller core, together with the stack pointer and a few resident special-function registers. The upper half of the address range, 80h to FFh, is shared by two physically separate storages: the upper 128 bytes of RAM and the special-function-register (SFR) window. A flag on each access request chooses between them. With the flag set to indirect, the access goes to upper RAM. With the flag set to direct, it goes to an SFR. The lower half, 00h to 7Fh, is always RAM.

The core issues one access per cycle. Each access carries an address, a write enable, write data and the addressing-mode flag. It also drives a separate push/pop port, which works on a stack pointer held inside the block. Stack traffic is always RAM traffic, so the stack can grow into the upper 128 bytes.

Direct accesses to SFR addresses that the block does not hold itself go out on a simple pass-through bus to the peripheral logic. Direct accesses to addresses that nobody occupies are absorbed deterministically.

Top module: `dual_space_dmem`

## Requirements
- R1: An access to an address in 00h–7Fh reads or writes the lower RAM bytes, with the same result in direct and indirect mode.
- R2: An indirect access to 80h–FFh reaches upper RAM, which is storage separate from the SFR at the same address. An indirect access never raises the external SFR strobes.
- R3: After reset the stack pointer reads 07h, the port-0 latch (SFR 80h) reads FFh, and the data-pointer low byte (82h), the data-pointer high byte (83h) and the power-control register (87h) read 00h.
- R4: A push (stack push high, pop low) increments the stack pointer at the clock edge and writes the push data to RAM at the incremented value.
- R5: Pop data always shows the RAM byte at the current stack pointer. A pop decrements the pointer at the clock edge. The pointer wraps modulo 256 in both directions.
- R6: When push and pop are requested in the same cycle, the pop takes effect: the pointer decrements and no RAM byte is written.
- R7: A direct access to an SFR address that is neither resident nor external reads 00h. A write to such an address changes nothing and raises no external strobe.
- R8: The external SFR addresses are 88h–8Dh, 90h, 98h, 99h, A0h, A8h, B0h, B8h, C8h–CDh, D0h, E0h and F0h. A direct access to one of them raises the read or write strobe for that cycle, presents the address and write data, and returns the bus read data.
- R9: The stack pointer reads and writes as the direct SFR at 81h. If a stack operation falls in the same cycle as a direct write to 81h, the stack operation wins.
- R10: Read data is combinational from the addressed storage. A write becomes visible only after the rising clock edge, so in the cycle of a write, a read of the same location returns the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access request present this cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_indirect | input | 1 | 1 = indirect mode, 0 = direct mode |
| acc_addr | input | 8 | Access address |
| acc_wdata | input | 8 | Access write data |
| acc_rdata | output | 8 | Access read data (combinational) |
| stk_push | input | 1 | Push request |
| stk_pop | input | 1 | Pop request |
| stk_wdata | input | 8 | Push data |
| stk_rdata | output | 8 | RAM byte at current stack pointer |
| sp_o | output | 8 | Current stack pointer |
| p0_o | output | 8 | Port-0 latch |
| dptr_o | output | 16 | Data pointer {high, low} |
| pcon_o | output | 8 | Power-control register |
| sfr_rd | output | 1 | External SFR read strobe |
| sfr_wr | output | 1 | External SFR write strobe |
| sfr_addr | output | 8 | External SFR address |
| sfr_wdata | output | 8 | External SFR write data |
| sfr_rdata | input | 8 | External SFR read data |

## Verification
A wrong steering decision shows up on the very first access that goes to the wrong side. An indirect read of 82h, for example, would return the data-pointer byte instead of the RAM byte, or a strobe would appear on the SFR bus in the same cycle. A corrupted stack pointer appears on sp_o one cycle after the push or pop that caused it. It also shows later, when the data popped at stk_rdata differs from the data pushed at that depth. Wrap and push/pop collisions are driven on purpose, because an off-by-one there changes sp_o at the next edge.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

  localparam int unsigned DMEM_AW = 8;
  localparam int unsigned DMEM_DW = 8;

  // Resident SFR addresses (direct mode only)
  localparam logic [7:0] SFR_P0   = 8'h80;
  localparam logic [7:0] SFR_SP   = 8'h81;
  localparam logic [7:0] SFR_DPL  = 8'h82;
  localparam logic [7:0] SFR_DPH  = 8'h83;
  localparam logic [7:0] SFR_PCON = 8'h87;

  localparam logic [7:0] SP_RESET = 8'h07;

  typedef enum logic [2:0] {
    TGT_RAM  = 3'd0,
    TGT_SP   = 3'd1,
    TGT_RES  = 3'd2,
    TGT_EXT  = 3'd3,
    TGT_NONE = 3'd4
  } tgt_e;

  // Occupancy map of SFRs served over the external bus, indexed by addr-80h
  function automatic logic [127:0] ext_map_default();
    logic [127:0] m;
    m = '0;
    for (int i = 8'h08; i <= 8'h0D; i++) m[i] = 1'b1;
    for (int i = 8'h48; i <= 8'h4D; i++) m[i] = 1'b1;
    m[7'h10] = 1'b1;
    m[7'h18] = 1'b1;
    m[7'h19] = 1'b1;
    m[7'h20] = 1'b1;
    m[7'h28] = 1'b1;
    m[7'h30] = 1'b1;
    m[7'h38] = 1'b1;
    m[7'h50] = 1'b1;
    m[7'h60] = 1'b1;
    m[7'h70] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/dmem_ram.sv
module dmem_ram #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          wa_en,
  input  logic [AW-1:0] wa_addr,
  input  logic [DW-1:0] wa_data,
  input  logic          wb_en,
  input  logic [AW-1:0] wb_addr,
  input  logic [DW-1:0] wb_data,
  input  logic [AW-1:0] ra_addr,
  output logic [DW-1:0] ra_data,
  input  logic [AW-1:0] rb_addr,
  output logic [DW-1:0] rb_data
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  // Port B (stack) is applied last, so it wins on an address collision
  always_ff @(posedge clk) begin
    if (wa_en) mem_q[wa_addr] <= wa_data;
    if (wb_en) mem_q[wb_addr] <= wb_data;
  end

  assign ra_data = mem_q[ra_addr];
  assign rb_data = mem_q[rb_addr];

endmodule

// File: rtl/dmem_steer.sv
module dmem_steer
  import dmem_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter logic [(1<<(AW-1))-1:0] EXT_MAP = '0
) (
  input  logic          indirect,
  input  logic [AW-1:0] addr,
  input  logic          res_hit,
  output tgt_e          tgt
);
  logic upper;
  assign upper = addr[AW-1];

  always_comb begin
    if (!upper || indirect)           tgt = TGT_RAM;
    else if (addr == AW'(SFR_SP))     tgt = TGT_SP;
    else if (res_hit)                 tgt = TGT_RES;
    else if (EXT_MAP[addr[AW-2:0]])   tgt = TGT_EXT;
    else                              tgt = TGT_NONE;
  end

endmodule

// File: rtl/dmem_sp.sv
module dmem_sp
  import dmem_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_val,
  output logic [AW-1:0] sp_q,
  output logic [AW-1:0] sp_inc
);
  logic [AW-1:0] sp_d;
  logic          sp_en;

  assign sp_inc = sp_q + AW'(1);

  // Pop wins over push; a stack operation wins over a direct load
  always_comb begin
    sp_en = push | pop | ld_en;
    if (pop)       sp_d = sp_q - AW'(1);
    else if (push) sp_d = sp_inc;
    else           sp_d = ld_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sp_q <= AW'(SP_RESET);
    else if (sp_en) sp_q <= sp_d;
  end

endmodule

// File: rtl/dmem_sfr_bank.sv
module dmem_sfr_bank #(
  parameter int unsigned AW   = 8,
  parameter int unsigned DW   = 8,
  parameter int unsigned NREG = 4,
  parameter logic [NREG-1:0][AW-1:0] REG_ADDR = '0,
  parameter logic [NREG-1:0][DW-1:0] REG_RST  = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [AW-1:0]            addr,
  input  logic [DW-1:0]            wdata,
  output logic                     hit,
  output logic [DW-1:0]            rdata,
  output logic [NREG-1:0][DW-1:0]  regs_q
);
  logic [NREG-1:0] sel;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic          en;
    logic [DW-1:0] d;

    assign sel[g] = (addr == REG_ADDR[g]);

    always_comb begin
      en = wr_en & sel[g];
      d  = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  regs_q[g] <= REG_RST[g];
      else if (en) regs_q[g] <= d;
    end
  end

  always_comb begin
    hit   = |sel;
    rdata = '0;
    for (int i = 0; i < NREG; i++) begin
      if (sel[i]) rdata = regs_q[i];
    end
  end

endmodule

// File: rtl/dual_space_dmem.sv
module dual_space_dmem
  import dmem_pkg::*;
#(
  parameter int unsigned AW = DMEM_AW,
  parameter int unsigned DW = DMEM_DW,
  parameter logic [(1<<(AW-1))-1:0] EXT_MAP = ext_map_default()
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc_valid,
  input  logic            acc_we,
  input  logic            acc_indirect,
  input  logic [AW-1:0]   acc_addr,
  input  logic [DW-1:0]   acc_wdata,
  output logic [DW-1:0]   acc_rdata,
  input  logic            stk_push,
  input  logic            stk_pop,
  input  logic [DW-1:0]   stk_wdata,
  output logic [DW-1:0]   stk_rdata,
  output logic [AW-1:0]   sp_o,
  output logic [DW-1:0]   p0_o,
  output logic [2*DW-1:0] dptr_o,
  output logic [DW-1:0]   pcon_o,
  output logic            sfr_rd,
  output logic            sfr_wr,
  output logic [AW-1:0]   sfr_addr,
  output logic [DW-1:0]   sfr_wdata,
  input  logic [DW-1:0]   sfr_rdata
);
  localparam int unsigned NREG = 4;
  localparam logic [NREG-1:0][AW-1:0] RES_ADDR =
    {AW'(SFR_PCON), AW'(SFR_DPH), AW'(SFR_DPL), AW'(SFR_P0)};
  localparam logic [NREG-1:0][DW-1:0] RES_RST =
    {DW'(0), DW'(0), DW'(0), {DW{1'b1}}};

  // Reset: asserted asynchronously, released on the clock
  logic rst_s0_q, rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0_q <= 1'b0;
      rst_q_n  <= 1'b0;
    end else begin
      rst_s0_q <= 1'b1;
      rst_q_n  <= rst_s0_q;
    end
  end

  tgt_e                   tgt;
  logic                   res_hit;
  logic [DW-1:0]          res_rdata;
  logic [NREG-1:0][DW-1:0] res_regs;
  logic                   acc_wr, acc_rd;
  logic                   ram_wa_en, ram_wb_en;
  logic [DW-1:0]          ram_ra_data;
  logic [AW-1:0]          sp_q, sp_inc;
  logic                   stk_push_eff;

  assign acc_wr       = acc_valid &  acc_we;
  assign acc_rd       = acc_valid & ~acc_we;
  assign stk_push_eff = stk_push & ~stk_pop;

  dmem_steer #(.AW(AW), .EXT_MAP(EXT_MAP)) i_steer (
    .indirect (acc_indirect),
    .addr     (acc_addr),
    .res_hit  (res_hit),
    .tgt      (tgt)
  );

  dmem_sp #(.AW(AW)) i_sp (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .push   (stk_push_eff),
    .pop    (stk_pop),
    .ld_en  (acc_wr && tgt == TGT_SP),
    .ld_val (acc_wdata[AW-1:0]),
    .sp_q   (sp_q),
    .sp_inc (sp_inc)
  );

  dmem_sfr_bank #(
    .AW(AW), .DW(DW), .NREG(NREG), .REG_ADDR(RES_ADDR), .REG_RST(RES_RST)
  ) i_bank (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .wr_en  (acc_wr && tgt == TGT_RES),
    .addr   (acc_addr),
    .wdata  (acc_wdata),
    .hit    (res_hit),
    .rdata  (res_rdata),
    .regs_q (res_regs)
  );

  assign ram_wa_en = acc_wr && tgt == TGT_RAM;
  assign ram_wb_en = stk_push_eff;

  dmem_ram #(.AW(AW), .DW(DW)) i_ram (
    .clk     (clk),
    .wa_en   (ram_wa_en),
    .wa_addr (acc_addr),
    .wa_data (acc_wdata),
    .wb_en   (ram_wb_en),
    .wb_addr (sp_inc),
    .wb_data (stk_wdata),
    .ra_addr (acc_addr),
    .ra_data (ram_ra_data),
    .rb_addr (sp_q),
    .rb_data (stk_rdata)
  );

  // External SFR pass-through
  assign sfr_rd    = acc_rd && tgt == TGT_EXT;
  assign sfr_wr    = acc_wr && tgt == TGT_EXT;
  assign sfr_addr  = acc_addr;
  assign sfr_wdata = acc_wdata;

  always_comb begin
    unique case (tgt)
      TGT_RAM: acc_rdata = ram_ra_data;
      TGT_SP:  acc_rdata = DW'(sp_q);
      TGT_RES: acc_rdata = res_rdata;
      TGT_EXT: acc_rdata = sfr_rdata;
      default: acc_rdata = '0;
    endcase
  end

  assign sp_o   = sp_q;
  assign p0_o   = res_regs[0];
  assign dptr_o = {res_regs[2], res_regs[1]};
  assign pcon_o = res_regs[3];

endmodule

// File: rtl/dmem_chk.sv
module dmem_chk #(
  parameter int unsigned AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_valid,
  input logic          acc_we,
  input logic          acc_indirect,
  input logic [AW-1:0] acc_addr,
  input logic          stk_push,
  input logic          stk_pop,
  input logic [AW-1:0] sp_o,
  input logic          sfr_rd,
  input logic          sfr_wr
);

  p_sp_reset_r3: assert property (@(posedge clk)
    !rst_n |=> sp_o == AW'(8'h07));

  p_lower_no_bus_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_addr[AW-1]) |-> (!sfr_rd && !sfr_wr));

  p_indirect_no_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_indirect) |-> (!sfr_rd && !sfr_wr));

  p_push_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_push && !stk_pop) |=> sp_o == $past(sp_o) + AW'(1));

  p_pop_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_pop && !stk_push) |=> sp_o == $past(sp_o) - AW'(1));

  p_collide_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_pop && stk_push) |=> sp_o == $past(sp_o) - AW'(1));

  p_strobe_direct_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_rd || sfr_wr) |-> (acc_valid && !acc_indirect && acc_addr[AW-1]));

  p_sp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!stk_push && !stk_pop &&
     !(acc_valid && acc_we && !acc_indirect && acc_addr == AW'(8'h81)))
    |=> $stable(sp_o));

endmodule

bind dual_space_dmem dmem_chk #(.AW(AW)) i_chk (
  .clk          (clk),
  .rst_n        (rst_q_n),
  .acc_valid    (acc_valid),
  .acc_we       (acc_we),
  .acc_indirect (acc_indirect),
  .acc_addr     (acc_addr),
  .stk_push     (stk_push),
  .stk_pop      (stk_pop),
  .sp_o         (sp_o),
  .sfr_rd       (sfr_rd),
  .sfr_wr       (sfr_wr)
);

// File: tb/test_dual_space_dmem.sv
module test_dual_space_dmem;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_valid, acc_we, acc_indirect;
  logic [7:0]  acc_addr, acc_wdata, acc_rdata;
  logic        stk_push, stk_pop;
  logic [7:0]  stk_wdata, stk_rdata, sp_o, p0_o, pcon_o;
  logic [15:0] dptr_o;
  logic        sfr_rd, sfr_wr;
  logic [7:0]  sfr_addr, sfr_wdata, sfr_rdata;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  // Peripheral model: read data derived from the address
  assign sfr_rdata = sfr_addr ^ 8'h5A;

  dual_space_dmem i_dual_space_dmem (
    .clk, .rst_n, .acc_valid, .acc_we, .acc_indirect, .acc_addr, .acc_wdata,
    .acc_rdata, .stk_push, .stk_pop, .stk_wdata, .stk_rdata, .sp_o, .p0_o,
    .dptr_o, .pcon_o, .sfr_rd, .sfr_wr, .sfr_addr, .sfr_wdata, .sfr_rdata
  );

  // {we, indirect, addr, wdata, expected read}
  localparam int NV = 23;
  localparam logic [25:0] VEC [NV] = '{
    {1'b1, 1'b0, 8'h10, 8'h11, 8'h00},
    {1'b1, 1'b1, 8'h20, 8'h22, 8'h00},
    {1'b0, 1'b1, 8'h10, 8'h00, 8'h11},  // R1
    {1'b0, 1'b0, 8'h20, 8'h00, 8'h22},  // R1
    {1'b1, 1'b1, 8'h90, 8'h33, 8'h00},
    {1'b1, 1'b1, 8'hA0, 8'h44, 8'h00},
    {1'b0, 1'b1, 8'h90, 8'h00, 8'h33},  // R2
    {1'b0, 1'b0, 8'h90, 8'h00, 8'hCA},  // R8
    {1'b1, 1'b0, 8'h82, 8'h5E, 8'h00},
    {1'b1, 1'b1, 8'h82, 8'h77, 8'h00},
    {1'b0, 1'b0, 8'h82, 8'h00, 8'h5E},  // R2
    {1'b0, 1'b1, 8'h82, 8'h00, 8'h77},  // R2
    {1'b1, 1'b0, 8'h84, 8'h99, 8'h00},
    {1'b0, 1'b0, 8'h84, 8'h00, 8'h00},  // R7
    {1'b1, 1'b1, 8'h84, 8'h66, 8'h00},
    {1'b0, 1'b1, 8'h84, 8'h00, 8'h66},  // R2
    {1'b0, 1'b0, 8'hFF, 8'h00, 8'h00},  // R7
    {1'b1, 1'b0, 8'h87, 8'hA5, 8'h00},
    {1'b0, 1'b0, 8'h87, 8'h00, 8'hA5},
    {1'b1, 1'b0, 8'h80, 8'h3C, 8'h00},
    {1'b0, 1'b0, 8'h80, 8'h00, 8'h3C},
    {1'b0, 1'b0, 8'hA0, 8'h00, 8'hFA},  // R8
    {1'b0, 1'b1, 8'hA0, 8'h00, 8'h44}   // R2
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    acc_valid = 0; acc_we = 0; acc_indirect = 0; acc_addr = 0; acc_wdata = 0;
    stk_push = 0; stk_pop = 0; stk_wdata = 0;
  endtask

  // Drive an access at the falling edge; the caller samples after #1
  task automatic drive(input logic we, input logic ind, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    idle();
    acc_valid = 1; acc_we = we; acc_indirect = ind; acc_addr = a; acc_wdata = d;
    #1;
  endtask

  task automatic read_chk(input string req, input logic ind, input logic [7:0] a, input logic [7:0] exp);
    drive(1'b0, ind, a, 8'h00);
    chk(req, {8'h00, acc_rdata}, {8'h00, exp});
  endtask

  task automatic stack_op(input logic push, input logic pop, input logic [7:0] d);
    @(negedge clk);
    idle();
    stk_push = push; stk_pop = pop; stk_wdata = d;
    #1;
  endtask

  task automatic settle();
    @(negedge clk);
    idle();
    #1;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R3 reset state
    settle();
    chk("R3 sp", {8'h00, sp_o}, 16'h0007);
    chk("R3 p0", {8'h00, p0_o}, 16'h00FF);
    chk("R3 dptr", dptr_o, 16'h0000);
    chk("R3 pcon", {8'h00, pcon_o}, 16'h0000);
    read_chk("R3 p0 via 80h", 1'b0, 8'h80, 8'hFF);
    read_chk("R3 sp via 81h", 1'b0, 8'h81, 8'h07);
    read_chk("R3 dph via 83h", 1'b0, 8'h83, 8'h00);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][25], VEC[i][24], VEC[i][23:16], VEC[i][15:8]);
      if (!VEC[i][25])
        chk($sformatf("R1/R2/R7/R8 vec%0d", i), {8'h00, acc_rdata}, {8'h00, VEC[i][7:0]});
    end
    settle();
    chk("R7 dptr after unoccupied write", dptr_o, 16'h005E);

    // R4 push
    stack_op(1'b1, 1'b0, 8'hAB);
    settle();
    chk("R4 sp after push", {8'h00, sp_o}, 16'h0008);
    read_chk("R4 pushed byte", 1'b1, 8'h08, 8'hAB);
    stack_op(1'b1, 1'b0, 8'hCD);
    settle();
    chk("R4 sp after second push", {8'h00, sp_o}, 16'h0009);
    // R5 pop
    stack_op(1'b0, 1'b1, 8'h00);
    chk("R5 pop data", {8'h00, stk_rdata}, 16'h00CD);
    settle();
    chk("R5 sp after pop", {8'h00, sp_o}, 16'h0008);
    // R6 push+pop collision
    stack_op(1'b1, 1'b1, 8'hEE);
    settle();
    chk("R6 sp after collision", {8'h00, sp_o}, 16'h0007);
    read_chk("R6 no write", 1'b1, 8'h09, 8'hCD);

    // R9 SP via 81h, R5 wrap
    drive(1'b1, 1'b0, 8'h81, 8'hFF);
    settle();
    chk("R9 sp loaded", {8'h00, sp_o}, 16'h00FF);
    read_chk("R9 sp read 81h", 1'b0, 8'h81, 8'hFF);
    stack_op(1'b1, 1'b0, 8'h11);
    settle();
    chk("R5 wrap up", {8'h00, sp_o}, 16'h0000);
    read_chk("R4 push at wrapped sp", 1'b0, 8'h00, 8'h11);
    stack_op(1'b0, 1'b1, 8'h00);
    chk("R5 pop data at 00h", {8'h00, stk_rdata}, 16'h0011);
    settle();
    chk("R5 wrap down", {8'h00, sp_o}, 16'h00FF);
    // R9 stack op beats direct SP write
    drive(1'b1, 1'b0, 8'h81, 8'h40);
    stk_push = 1'b1; stk_wdata = 8'h22;
    settle();
    chk("R9 push beats 81h write", {8'h00, sp_o}, 16'h0000);

    // R8 external strobes
    drive(1'b1, 1'b0, 8'h98, 8'h3E);
    chk("R8 wr strobe", {15'h0, sfr_wr}, 16'h0001);
    chk("R8 wr addr/data", {sfr_addr, sfr_wdata}, 16'h983E);
    drive(1'b0, 1'b0, 8'h99, 8'h00);
    chk("R8 rd strobe", {15'h0, sfr_rd}, 16'h0001);
    chk("R8 rd data", {8'h00, acc_rdata}, 16'h00C3);
    drive(1'b1, 1'b0, 8'h84, 8'h12);
    chk("R7 no strobe", {14'h0, sfr_rd, sfr_wr}, 16'h0000);
    drive(1'b1, 1'b1, 8'h98, 8'h12);
    chk("R2 indirect no strobe", {14'h0, sfr_rd, sfr_wr}, 16'h0000);

    // R10 write timing
    drive(1'b1, 1'b1, 8'h30, 8'h01);
    drive(1'b1, 1'b1, 8'h30, 8'h02);
    chk("R10 old value before edge", {8'h00, acc_rdata}, 16'h0001);
    read_chk("R10 new value after edge", 1'b1, 8'h30, 8'h02);

    settle();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule